// File: doc/BRIEF.md
# ADC Result Formatter

This block sits between a converter's sequencing logic and the register file. It accepts raw conversion codes from two groups of channels and turns each into a 16-bit word ready to be read. The normal group owns one result register. The priority group owns several result slots, each with a programmable offset. The offset is subtracted from the code, and the signed outcome is clamped to the range of the selected resolution.

One control bit picks right or left placement for both groups. Placement works on the full 16-bit word at 12, 10 and 8 bits of resolution and on the low byte at 6 bits. Each update of the normal-group register can raise a one-cycle transfer request for a DMA engine. Updates of the priority group never raise it. Every result lands in its register on the clock edge that samples its valid strobe.

Top module: `adc_fmt_datapath`

## Requirements
- R1: While reset is asserted and after its release, ord_data, every pre_data slot, dma_req and every slot offset are zero.
- R2: When ord_valid is high at a clock edge, ord_data holds the formatted code from that edge on. Without ord_valid, ord_data keeps its value.
- R3: When pre_valid is high at an edge, only the slot chosen by pre_slot is written. Slot k is pre_data bits [16k+15:16k], and the other slots keep their values.
- R4: ofs_wr at an edge loads ofs_val into the offset of slot ofs_slot. A priority conversion sampled at the same edge still uses the previous offset.
- R5: A priority result is the masked code minus the slot offset, as a signed value clamped to the range -2^N to 2^N-1, where N is the resolution in bits.
- R6: With align_left low, normal results are zero-extended to 16 bits and priority results are sign-extended to 16 bits.
- R7: With align_left high at 12, 10 or 8 bits, a normal result is shifted left by 16-N. A priority result is shifted left by 15-N, so that bit 15 carries the sign.
- R8: At 6-bit resolution with align_left high, a normal result occupies bits [7:2] and all other bits are zero. A priority result occupies bits [7:1] with its sign at bit 7, bit 0 is zero, and bits [15:8] repeat the sign.
- R9: res_sel encodes the resolution as 0=12, 1=10, 2=8 and 3=6 bits. Raw code bits at or above bit N are ignored.
- R10: dma_req is high for exactly the cycle after an edge that samples ord_valid and dma_en both high, and is low otherwise. A priority write alone never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| align_left | input | 1 | 1 = left placement, 0 = right placement |
| res_sel | input | 2 | Resolution code (0=12, 1=10, 2=8, 3=6 bits) |
| dma_en | input | 1 | Enables the transfer request on normal updates |
| ord_valid | input | 1 | Normal-group conversion complete |
| ord_raw | input | 12 | Normal-group raw code |
| pre_valid | input | 1 | Priority-group conversion complete |
| pre_slot | input | 2 | Priority slot being written |
| pre_raw | input | 12 | Priority-group raw code |
| ofs_wr | input | 1 | Offset write strobe |
| ofs_slot | input | 2 | Slot whose offset is written |
| ofs_val | input | 12 | Offset value |
| ord_data | output | 16 | Normal-group result register |
| pre_data | output | 64 | Priority result registers, slot k at [16k+15:16k] |
| dma_req | output | 1 | One-cycle transfer request |

## Verification
Each result register and the transfer request pass through exactly one register stage. A strobe driven before edge c is therefore due at the falling edge that follows edge c. The driver records that due cycle in every expected item. The monitor compares an item only when the cycle counter reaches its due value, and it always samples on the falling edge. Each stimulus cycle pushes an expectation for every result slot and for the request, so values that must be held are checked in the same cycle as values that change. Offset writes take effect in the model only after the expectations for their own edge have been formed.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

   // Resolution code seen at the res_sel port; the numeric value is the
   // number of 2-bit steps below the full raw width.
   typedef enum logic [1:0] {
      RES_FULL  = 2'd0,
      RES_M2    = 2'd1,
      RES_M4    = 2'd2,
      RES_NARROW = 2'd3
   } res_e;

   // Width of the byte lane used by the narrowest resolution.
   localparam int unsigned LANE_W = 8;

   function automatic int unsigned res_bits(input int unsigned raw_w, input logic [1:0] code);
      return raw_w - 2 * int'(code);
   endfunction

endpackage

// File: rtl/adc_fmt_offset_bank.sv
module adc_fmt_offset_bank #(
   parameter int unsigned NUM_SLOTS = 4,
   parameter int unsigned RAW_W     = 12,
   localparam int unsigned SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [RAW_W-1:0]  wr_val,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic [RAW_W-1:0]  rd_val
);

   logic [RAW_W-1:0] ofs_q [NUM_SLOTS];

   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ofs_q[k] <= '0;
         end else if (wr_en && (wr_slot == SLOT_W'(k))) begin
            ofs_q[k] <= wr_val;
         end
      end
   end

   always_comb begin
      rd_val = '0;
      for (int k = 0; k < NUM_SLOTS; k++) begin
         if (rd_slot == SLOT_W'(k)) rd_val = ofs_q[k];
      end
   end

endmodule

// File: rtl/adc_fmt_offset_sub.sv
module adc_fmt_offset_sub #(
   parameter int unsigned RAW_W = 12
) (
   input  logic [RAW_W-1:0] raw,
   input  logic [RAW_W-1:0] ofs,
   input  logic [1:0]       res_sel,
   output logic [RAW_W-1:0] raw_masked,
   output logic [RAW_W:0]   val
);

   localparam int unsigned DW = RAW_W + 2;

   logic [RAW_W-1:0]     mask;
   logic signed [DW-1:0] diff;
   logic signed [DW-1:0] hi_lim;
   logic signed [DW-1:0] lo_lim;
   logic signed [DW-1:0] clamped;

   // Codes narrower than the raw field keep their data in the LSBs.
   assign mask       = {RAW_W{1'b1}} >> (2 * res_sel);
   assign raw_masked = raw & mask;

   assign diff   = $signed({2'b00, raw_masked}) - $signed({2'b00, ofs});
   assign hi_lim = $signed({2'b00, mask});
   assign lo_lim = -hi_lim - DW'(1);

   always_comb begin
      if (diff > hi_lim)      clamped = hi_lim;
      else if (diff < lo_lim) clamped = lo_lim;
      else                    clamped = diff;
   end

   assign val = clamped[RAW_W:0];

endmodule

// File: rtl/adc_fmt_align.sv
module adc_fmt_align #(
   parameter int unsigned RAW_W     = 12,
   parameter int unsigned OUT_W     = 16,
   parameter int unsigned LANE_W    = 8,
   parameter bit          SIGNED_IN = 1'b0
) (
   input  logic [RAW_W:0]   val,
   input  logic [1:0]       res_sel,
   input  logic             left,
   output logic [OUT_W-1:0] word
);

   localparam int unsigned SH_W = $clog2(OUT_W + 1);
   localparam int unsigned ADJ  = SIGNED_IN ? 1 : 0;
   localparam int unsigned EXT  = OUT_W - RAW_W - 1;

   logic [OUT_W-1:0] ext;
   logic [SH_W-1:0]  sh_left;
   logic [SH_W-1:0]  sh;

   if (SIGNED_IN) begin : g_sext
      assign ext = {{EXT{val[RAW_W]}}, val};
   end else begin : g_zext
      assign ext = {{EXT{1'b0}}, val};
   end

   // Word lane for all codes but the narrowest, which uses the byte lane.
   always_comb begin
      case (res_sel)
         2'd0:    sh_left = SH_W'(OUT_W  - RAW_W       - ADJ);
         2'd1:    sh_left = SH_W'(OUT_W  - (RAW_W - 2) - ADJ);
         2'd2:    sh_left = SH_W'(OUT_W  - (RAW_W - 4) - ADJ);
         default: sh_left = SH_W'(LANE_W - (RAW_W - 6) - ADJ);
      endcase
   end

   assign sh   = left ? sh_left : '0;
   assign word = ext << sh;

endmodule

// File: rtl/adc_fmt_datapath.sv
module adc_fmt_datapath #(
   parameter int unsigned NUM_SLOTS = 4,
   parameter int unsigned RAW_W     = 12,
   parameter int unsigned OUT_W     = 16,
   localparam int unsigned SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     align_left,
   input  logic [1:0]               res_sel,
   input  logic                     dma_en,
   input  logic                     ord_valid,
   input  logic [RAW_W-1:0]         ord_raw,
   input  logic                     pre_valid,
   input  logic [SLOT_W-1:0]        pre_slot,
   input  logic [RAW_W-1:0]         pre_raw,
   input  logic                     ofs_wr,
   input  logic [SLOT_W-1:0]        ofs_slot,
   input  logic [RAW_W-1:0]         ofs_val,
   output logic [OUT_W-1:0]         ord_data,
   output logic [NUM_SLOTS*OUT_W-1:0] pre_data,
   output logic                     dma_req
);

   import adc_fmt_pkg::*;

   if (NUM_SLOTS < 1) begin : g_bad_slots
      $error("NUM_SLOTS must be at least 1");
   end
   if (RAW_W < 8) begin : g_bad_raw
      $error("RAW_W must leave room for four resolutions");
   end
   if (OUT_W < RAW_W + 2) begin : g_bad_out
      $error("OUT_W must hold a signed result plus one left shift");
   end
   if (LANE_W < RAW_W - 6 + 2) begin : g_bad_lane
      $error("byte lane too narrow for the smallest resolution");
   end

   logic [RAW_W-1:0] cur_ofs;
   logic [RAW_W-1:0] pre_masked;
   logic [RAW_W-1:0] ord_masked;
   logic [RAW_W:0]   pre_val;
   logic [OUT_W-1:0] pre_word;
   logic [OUT_W-1:0] ord_word;
   logic [OUT_W-1:0] pre_q [NUM_SLOTS];

   adc_fmt_offset_bank #(
      .NUM_SLOTS(NUM_SLOTS),
      .RAW_W    (RAW_W)
   ) u_ofs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (ofs_wr),
      .wr_slot(ofs_slot),
      .wr_val (ofs_val),
      .rd_slot(pre_slot),
      .rd_val (cur_ofs)
   );

   adc_fmt_offset_sub #(.RAW_W(RAW_W)) u_sub (
      .raw       (pre_raw),
      .ofs       (cur_ofs),
      .res_sel   (res_sel),
      .raw_masked(pre_masked),
      .val       (pre_val)
   );

   adc_fmt_align #(
      .RAW_W    (RAW_W),
      .OUT_W    (OUT_W),
      .LANE_W   (LANE_W),
      .SIGNED_IN(1'b1)
   ) u_pre_align (
      .val    (pre_val),
      .res_sel(res_sel),
      .left   (align_left),
      .word   (pre_word)
   );

   assign ord_masked = ord_raw & ({RAW_W{1'b1}} >> (2 * res_sel));

   adc_fmt_align #(
      .RAW_W    (RAW_W),
      .OUT_W    (OUT_W),
      .LANE_W   (LANE_W),
      .SIGNED_IN(1'b0)
   ) u_ord_align (
      .val    ({1'b0, ord_masked}),
      .res_sel(res_sel),
      .left   (align_left),
      .word   (ord_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ord_data <= '0;
         dma_req  <= 1'b0;
      end else begin
         if (ord_valid) ord_data <= ord_word;
         dma_req <= ord_valid & dma_en;
      end
   end

   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_pre
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pre_q[k] <= '0;
         end else if (pre_valid && (pre_slot == SLOT_W'(k))) begin
            pre_q[k] <= pre_word;
         end
      end
      assign pre_data[k*OUT_W +: OUT_W] = pre_q[k];
   end

   // Masked priority code is not needed beyond the subtractor.
   logic unused_ok;
   assign unused_ok = ^pre_masked;

endmodule

// File: rtl/adc_fmt_datapath_chk.sv
module adc_fmt_datapath_chk #(
   parameter int unsigned NUM_SLOTS = 4,
   parameter int unsigned RAW_W     = 12,
   parameter int unsigned OUT_W     = 16,
   localparam int unsigned SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       align_left,
   input logic [1:0]                 res_sel,
   input logic                       dma_en,
   input logic                       ord_valid,
   input logic                       pre_valid,
   input logic [SLOT_W-1:0]          pre_slot,
   input logic [OUT_W-1:0]           ord_data,
   input logic [NUM_SLOTS*OUT_W-1:0] pre_data,
   input logic                       dma_req
);

   // R10: request follows an enabled normal update by one cycle
   a_r10_dma_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (ord_valid && dma_en) |=> dma_req);

   // R10: no request without an enabled normal update
   a_r10_no_spurious_dma: assert property (@(posedge clk) disable iff (!rst_n)
      !(ord_valid && dma_en) |=> !dma_req);

   // R2: normal register holds when not written
   a_r2_ord_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ord_valid |=> $stable(ord_data));

   // R7: left placement at full resolution leaves the low nibble clear
   a_r7_left_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ord_valid && align_left && res_sel == 2'd0) |=> (ord_data[3:0] == 4'd0));

   // R8: narrow left placement keeps the normal result inside bits [7:2]
   a_r8_narrow_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (ord_valid && align_left && res_sel == 2'd3)
         |=> (ord_data[OUT_W-1:8] == '0 && ord_data[1:0] == 2'd0));

   // R3: unselected slots keep their values
   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot_chk
      a_r3_other_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !(pre_valid && pre_slot == SLOT_W'(k))
            |=> $stable(pre_data[k*OUT_W +: OUT_W]));
   end

endmodule

bind adc_fmt_datapath adc_fmt_datapath_chk #(
   .NUM_SLOTS(NUM_SLOTS),
   .RAW_W    (RAW_W),
   .OUT_W    (OUT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .align_left(align_left),
   .res_sel   (res_sel),
   .dma_en    (dma_en),
   .ord_valid (ord_valid),
   .pre_valid (pre_valid),
   .pre_slot  (pre_slot),
   .ord_data  (ord_data),
   .pre_data  (pre_data),
   .dma_req   (dma_req)
);

// File: tb/adc_fmt_datapath_test.sv
module adc_fmt_datapath_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        align_left = 1'b0;
   logic [1:0]  res_sel = 2'd0;
   logic        dma_en = 1'b0;
   logic        ord_valid = 1'b0;
   logic [11:0] ord_raw = '0;
   logic        pre_valid = 1'b0;
   logic [1:0]  pre_slot = '0;
   logic [11:0] pre_raw = '0;
   logic        ofs_wr = 1'b0;
   logic [1:0]  ofs_slot = '0;
   logic [11:0] ofs_val = '0;
   logic [15:0] ord_data;
   logic [63:0] pre_data;
   logic        dma_req;

   adc_fmt_datapath uut (.*);

   always #10 clk = ~clk;

   typedef struct {
      int          due;
      int          what;   // 0 = ord_data, 1..4 = slot, 5 = dma_req
      logic [15:0] exp;
      string       req;
   } item_t;

   item_t q[$];
   int cyc = 0;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   int          ofs_m [4];
   logic [15:0] pre_m [4];
   logic [15:0] ord_m;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [15:0] exp_ord(int raw, int res, bit left);
      int n, m, base;
      n = 12 - 2 * res;
      m = raw % (1 << n);
      base = (res == 3) ? 8 : 16;
      if (left) m = m * (1 << (base - n));
      return 16'(m);
   endfunction

   function automatic logic [15:0] exp_pre(int raw, int ofs, int res, bit left);
      int n, d, base;
      n = 12 - 2 * res;
      d = (raw % (1 << n)) - ofs;
      if (d > (1 << n) - 1) d = (1 << n) - 1;
      if (d < -(1 << n))    d = -(1 << n);
      base = (res == 3) ? 8 : 16;
      if (left) d = d * (1 << (base - 1 - n));
      return 16'(d);
   endfunction

   task automatic push(int what, logic [15:0] e, string req);
      item_t it;
      it.due = cyc + 1; it.what = what; it.exp = e; it.req = req;
      q.push_back(it);
   endtask

   task automatic drive(bit ov, int oraw, bit pv, int ps, int praw,
                        bit ow, int os, int oval, bit left, int res, bit den,
                        string req);
      @(negedge clk);
      ord_valid = ov; ord_raw = 12'(oraw);
      pre_valid = pv; pre_slot = 2'(ps); pre_raw = 12'(praw);
      ofs_wr = ow; ofs_slot = 2'(os); ofs_val = 12'(oval);
      align_left = left; res_sel = 2'(res); dma_en = den;
      if (ov) ord_m = exp_ord(oraw, res, left);
      if (pv) pre_m[ps] = exp_pre(praw, ofs_m[ps], res, left);
      push(0, ord_m, req);
      for (int k = 0; k < 4; k++) push(1 + k, pre_m[k], req);
      push(5, {15'd0, ov && den}, "R10");
      if (ow) ofs_m[os] = oval;   // R4: later conversions see the new offset
   endtask

   task automatic idle();
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
   endtask

   // Monitor: compare each expected item in the cycle it is due.
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].due <= cyc) begin
         item_t it;
         logic [15:0] act;
         it = q.pop_front();
         if (it.what == 0)      act = ord_data;
         else if (it.what == 5) act = {15'd0, dma_req};
         else                   act = pre_data[(it.what - 1) * 16 +: 16];
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s item %0d cycle %0d: actual %h expected %h",
                     it.req, it.what, cyc, act, it.exp);
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 4; k++) begin ofs_m[k] = 0; pre_m[k] = '0; end
      ord_m = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      checks++;
      if (ord_data !== 16'd0 || pre_data !== 64'd0 || dma_req !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset: actual %h %h %b expected 0 0 0", ord_data, pre_data, dma_req);
      end
      rst_n = 1'b1;
      idle();
      // R1: offsets are zero after reset, R6 right sign extension
      drive(0, 0, 1, 2, 12'h7AB, 0, 0, 0, 0, 0, 0, "R1");
      // R4: program offsets
      drive(0, 0, 0, 0, 0, 1, 0, 12'h200, 0, 0, 0, "R4");
      drive(0, 0, 0, 0, 0, 1, 1, 12'h010, 0, 0, 0, "R4");
      drive(0, 0, 0, 0, 0, 1, 3, 12'hFFF, 0, 0, 0, "R4");
      // R5 / R6: negative and positive results, right placement, 12 bit
      drive(1, 12'h123, 1, 0, 12'h123, 0, 0, 0, 0, 0, 1, "R6");
      drive(1, 12'hABC, 1, 1, 12'hABC, 0, 0, 0, 0, 0, 0, "R5");
      // R5: most negative result at full width
      drive(0, 0, 1, 3, 12'h000, 0, 0, 0, 0, 0, 0, "R5");
      // R7: left placement at 12, 10 and 8 bits
      drive(1, 12'hFFF, 1, 0, 12'h0FF, 0, 0, 0, 1, 0, 1, "R7");
      drive(1, 12'h3FF, 1, 1, 12'h005, 0, 0, 0, 1, 1, 0, "R7");
      drive(1, 12'h0A5, 1, 2, 12'h0A5, 0, 0, 0, 1, 2, 1, "R7");
      // R8: 6-bit narrow lane, left; R5 clamps to -64 with offset 0x200
      drive(1, 12'h03F, 1, 0, 12'h03F, 0, 0, 0, 1, 3, 0, "R8");
      drive(0, 0, 1, 2, 12'h02A, 0, 0, 0, 1, 3, 0, "R8");
      drive(0, 0, 1, 2, 12'h02A, 0, 0, 0, 0, 3, 0, "R6");
      // R9: bits above the resolution are ignored
      drive(1, 12'hFC1, 1, 2, 12'hFC1, 0, 0, 0, 0, 3, 1, "R9");
      drive(1, 12'hC05, 1, 1, 12'hC05, 0, 0, 0, 0, 1, 0, "R9");
      // R4: same-edge offset write and conversion use the old offset
      drive(0, 0, 1, 1, 12'h100, 1, 1, 12'h080, 0, 0, 0, "R4");
      drive(0, 0, 1, 1, 12'h100, 0, 0, 0, 0, 0, 0, "R4");
      // R3: each slot written alone, others hold
      for (int k = 0; k < 4; k++) drive(0, 0, 1, k, 12'h800 + k, 0, 0, 0, 1, 0, 0, "R3");
      // R10: priority write alone raises no request; back-to-back requests
      drive(0, 0, 1, 0, 12'h001, 0, 0, 0, 0, 0, 1, "R10");
      drive(1, 12'h111, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R10");
      drive(1, 12'h222, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R10");
      drive(1, 12'h333, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
      idle();
      idle();
      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule